// File: doc/BRIEF.md
# Event-Triggered Sync Counter Unit

This unit lets software arrange for a counter to advance at the moment a hardware capture event happens. Software writes a request naming an event condition and a counter. The request waits in a two-entry queue that belongs to that condition. When the condition's event pulse arrives, the oldest waiting request for that condition is retired and the counter it names goes up by one. Software then polls the counter against a threshold to learn that a frame has started or that a buffer's memory writes have completed.

Each capture port p drives two event pulses: frame start, on condition code 5+4p, and memory-write-done, on condition code 7+4p. The host port sets what happens when a request meets a full queue. In the default stalling mode the host port lowers `wr_ready` until space appears. In no-stall mode the request is discarded and the condition's bit is set in a write-one-to-clear error register. Software can also bump a counter directly, which lets it account for events that timed out.

The host side is a two-state machine. `HOST_OPEN` accepts writes, with `wr_ready` high. `HOST_OPEN -> HOST_STALLED` is taken when a request finds its queue full, no pop happens in that cycle and stalling mode is active. The request is then held inside the unit. `HOST_STALLED -> HOST_STALLED` repeats while the queue stays full. `HOST_STALLED -> HOST_OPEN` is taken in the cycle the held request enters its queue. `HOST_OPEN -> HOST_OPEN` covers every other case.

Top module: `event_sync_counter`

## Requirements
- R1: A write to address 0 is a request. Bits 15:8 of the data hold the condition code and bits 7:0 hold the counter index. A code at or above the number of conditions (4·NPORT+4) is dropped without effect.
- R2: On port p, the `fs_evt[p]` pulse serves condition 5+4p and the `ack_evt[p]` pulse serves condition 7+4p.
- R3: Each condition queues at most two pending requests.
- R4: An event pulse retires the oldest pending request of its condition and adds one to the named counter, in request order. Counters are 32 bits wide and read combinationally through `rd_idx`/`rd_count`.
- R5: An event pulse on a condition with an empty queue changes no counter.
- R6: After reset the unit is in stalling mode. A request that meets a full queue is accepted and held, and `wr_ready` stays low from the next cycle until an event frees a slot. The held request then enters the queue and `wr_ready` returns high.
- R7: Setting bit 8 of address 1 selects no-stall mode. A request that meets a full queue is then discarded, error bit [code] is set and `wr_ready` stays high.
- R8: Error bits clear only through a write to address 2, which clears exactly the bits written as one.
- R9: A request and an event hitting a full queue in the same cycle both take effect, and no error is raised.
- R10: A write to address 3 adds one to the counter indexed by data bits 7:0. An index at or above NUM_CNT has no effect.
- R11: Pops from several conditions in one cycle that name the same counter all add to it.
- R12: Reset clears all counters and error bits and leaves `wr_ready` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 2 | Host address: 0 request, 1 control, 2 error clear, 3 direct bump |
| wr_data | input | 32 | Host write data |
| wr_ready | output | 1 | High when a write is taken this cycle |
| fs_evt | input | NPORT | Frame-start pulses, one per port |
| ack_evt | input | NPORT | Memory-write-done pulses, one per port |
| rd_idx | input | 8 | Counter select for read-back |
| rd_count | output | 32 | Value of the selected counter |
| err_flags | output | 4·NPORT+4 | Dropped-request flag per condition |

## Verification
The bench targets four risky points: queue order, the two full-queue policies, the same-cycle push and pop on a full queue, and counters that are hit by several sources at once. A queue that pops from the tail would bump the wrong counter. A stall that loses its held request would leave a counter one short. A design that checks fullness before the pop would stall or flag an error on a write that should succeed. A single-increment adder would undercount when several conditions retire into one counter in the same cycle. The bench also sweeps every counter against every event condition, which catches a wrong code-to-port mapping.

// File: rtl/esc_pkg.sv
package esc_pkg;
    typedef enum logic {
        HOST_OPEN    = 1'b0,
        HOST_STALLED = 1'b1
    } host_st_e;

    localparam logic [1:0] ADDR_REQ  = 2'd0;
    localparam logic [1:0] ADDR_CTRL = 2'd1;
    localparam logic [1:0] ADDR_ERR  = 2'd2;
    localparam logic [1:0] ADDR_BUMP = 2'd3;
    localparam int         NOSTALL_BIT = 8;
    localparam int         IDX_W = 8;
endpackage

// File: rtl/esc_cond_fifo.sv
module esc_cond_fifo #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] din,
    output logic [W-1:0] head,
    output logic         full,
    output logic         empty
);
    logic [W-1:0] slot0_q, slot1_q;
    logic [1:0]   cnt_q;
    logic         pop_ok;

    assign pop_ok = pop && (cnt_q != 2'd0);
    assign head   = slot0_q;
    assign full   = (cnt_q == 2'd2);
    assign empty  = (cnt_q == 2'd0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot0_q <= '0;
            slot1_q <= '0;
            cnt_q   <= 2'd0;
        end else begin
            unique case ({push, pop_ok})
                2'b10: begin
                    if (cnt_q == 2'd0) slot0_q <= din;
                    else               slot1_q <= din;
                    cnt_q <= cnt_q + 2'd1;
                end
                2'b01: begin
                    slot0_q <= slot1_q;
                    cnt_q   <= cnt_q - 2'd1;
                end
                2'b11: begin
                    if (cnt_q == 2'd1) begin
                        slot0_q <= din;
                    end else begin
                        slot0_q <= slot1_q;
                        slot1_q <= din;
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/esc_counter_bank.sv
module esc_counter_bank #(
    parameter int NUM_CNT = 8,
    parameter int CW      = 32,
    parameter int NSRC    = 13
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    hit_vld [NSRC],
    input  logic [esc_pkg::IDX_W-1:0] hit_idx [NSRC],
    input  logic [esc_pkg::IDX_W-1:0] rd_idx,
    output logic [CW-1:0]           rd_val
);
    localparam int SUM_W = $clog2(NSRC + 1);
    localparam int SEL_W = (NUM_CNT > 1) ? $clog2(NUM_CNT) : 1;

    logic [CW-1:0] cnt_q [NUM_CNT];

    for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
        logic [SUM_W-1:0] add;
        always_comb begin
            add = '0;
            for (int s = 0; s < NSRC; s++) begin
                if (hit_vld[s] && (hit_idx[s] == esc_pkg::IDX_W'(i)))
                    add = add + SUM_W'(1);
            end
        end
        always_ff @(posedge clk) begin
            if (!rst_n) cnt_q[i] <= '0;
            else        cnt_q[i] <= cnt_q[i] + CW'(add);
        end
    end

    assign rd_val = (rd_idx < esc_pkg::IDX_W'(NUM_CNT)) ? cnt_q[rd_idx[SEL_W-1:0]] : '0;
endmodule

// File: rtl/event_sync_counter.sv
module event_sync_counter
    import esc_pkg::*;
#(
    parameter int NPORT    = 2,
    parameter int NUM_CNT  = 8,
    parameter int CW       = 32,
    parameter int NUM_COND = 4 * NPORT + 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [1:0]          wr_addr,
    input  logic [31:0]         wr_data,
    output logic                wr_ready,
    input  logic [NPORT-1:0]    fs_evt,
    input  logic [NPORT-1:0]    ack_evt,
    input  logic [IDX_W-1:0]    rd_idx,
    output logic [CW-1:0]       rd_count,
    output logic [NUM_COND-1:0] err_flags
);
    localparam int NSRC = NUM_COND + 1;

    host_st_e              state_q, state_d;
    logic                  nostall_q;
    logic [NUM_COND-1:0]   err_q;
    logic [IDX_W-1:0]      hold_cond_q, hold_idx_q;
    logic [IDX_W-1:0]      cur_cond, cur_idx;
    logic                  push_want, blocked, take_hold, drop_req, wr_acc;
    logic [NUM_COND-1:0]   ev_vec, sel, room, push_vec, pop_ok, full_v, empty_v;
    logic [IDX_W-1:0]      head_v [NUM_COND];
    logic                  hit_vld [NSRC];
    logic [IDX_W-1:0]      hit_idx [NSRC];
    logic                  unused_hi;

    assign unused_hi = ^wr_data[31:16];

    // Event routing: frame start on 5+4p, write-done on 7+4p
    for (genvar c = 0; c < NUM_COND; c++) begin : g_ev
        if (c >= 5 && ((c - 5) % 4) == 0) begin : g_fs
            assign ev_vec[c] = fs_evt[(c - 5) / 4];
        end else if (c >= 7 && ((c - 7) % 4) == 0) begin : g_ack
            assign ev_vec[c] = ack_evt[(c - 7) / 4];
        end else begin : g_none
            assign ev_vec[c] = 1'b0;
        end
    end

    assign wr_acc   = wr_en && wr_ready;
    assign cur_cond = (state_q == HOST_STALLED) ? hold_cond_q : wr_data[15:8];
    assign cur_idx  = (state_q == HOST_STALLED) ? hold_idx_q  : wr_data[7:0];
    assign push_want = ((state_q == HOST_STALLED) || (wr_en && wr_addr == ADDR_REQ))
                       && (cur_cond < IDX_W'(NUM_COND));

    for (genvar c = 0; c < NUM_COND; c++) begin : g_q
        assign sel[c]      = (cur_cond == IDX_W'(c));
        assign pop_ok[c]   = ev_vec[c] && !empty_v[c];
        assign room[c]     = !full_v[c] || pop_ok[c];
        assign push_vec[c] = push_want && sel[c] && room[c];
        assign hit_vld[c]  = pop_ok[c];
        assign hit_idx[c]  = head_v[c];

        esc_cond_fifo #(.W(IDX_W)) u_fifo (
            .clk   (clk),
            .rst_n (rst_n),
            .push  (push_vec[c]),
            .pop   (ev_vec[c]),
            .din   (cur_idx),
            .head  (head_v[c]),
            .full  (full_v[c]),
            .empty (empty_v[c])
        );
    end

    assign blocked = push_want && |(sel & ~room);

    assign hit_vld[NUM_COND] = wr_acc && (wr_addr == ADDR_BUMP);
    assign hit_idx[NUM_COND] = wr_data[7:0];

    // Host state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= HOST_OPEN;
        else        state_q <= state_d;
    end

    // Host next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            HOST_OPEN:    state_d = (blocked && !nostall_q) ? HOST_STALLED : HOST_OPEN;
            HOST_STALLED: state_d = blocked ? HOST_STALLED : HOST_OPEN;
            default:      state_d = HOST_OPEN;
        endcase
    end

    // Host outputs
    always_comb begin
        wr_ready  = 1'b0;
        take_hold = 1'b0;
        drop_req  = 1'b0;
        unique case (state_q)
            HOST_OPEN: begin
                wr_ready  = 1'b1;
                take_hold = blocked && !nostall_q;
                drop_req  = blocked && nostall_q;
            end
            HOST_STALLED: wr_ready = 1'b0;
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_cond_q <= '0;
            hold_idx_q  <= '0;
            nostall_q   <= 1'b0;
            err_q       <= '0;
        end else begin
            if (take_hold) begin
                hold_cond_q <= wr_data[15:8];
                hold_idx_q  <= wr_data[7:0];
            end
            if (wr_acc && wr_addr == ADDR_CTRL)
                nostall_q <= wr_data[NOSTALL_BIT];
            err_q <= (err_q & ~((wr_acc && wr_addr == ADDR_ERR) ? wr_data[NUM_COND-1:0]
                                                                 : '0))
                     | (sel & {NUM_COND{drop_req}});
        end
    end

    assign err_flags = err_q;

    esc_counter_bank #(.NUM_CNT(NUM_CNT), .CW(CW), .NSRC(NSRC)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .hit_vld (hit_vld),
        .hit_idx (hit_idx),
        .rd_idx  (rd_idx),
        .rd_val  (rd_count)
    );
endmodule

// File: rtl/esc_checker.sv
module esc_checker #(
    parameter int NPORT    = 2,
    parameter int CW       = 32,
    parameter int NUM_COND = 4 * NPORT + 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic                wr_en,
    input logic [1:0]          wr_addr,
    input logic                wr_ready,
    input logic [NPORT-1:0]    fs_evt,
    input logic [NPORT-1:0]    ack_evt,
    input logic [7:0]          rd_idx,
    input logic [CW-1:0]       rd_count,
    input logic [NUM_COND-1:0] err_flags,
    input logic                nostall_q
);
    // R5: no event and no bump -> selected counter unchanged
    a_r5_quiet_counters: assert property (@(posedge clk) disable iff (!rst_n)
        ($stable(rd_idx) && $past(!(|fs_evt) && !(|ack_evt)
                                  && !(wr_en && wr_ready && wr_addr == 2'd3)))
        |-> $stable(rd_count));

    // R11: one cycle adds at most one per event source plus the bump
    a_r11_bounded_step: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(rd_idx) |-> ((rd_count - $past(rd_count)) <= CW'(2 * NPORT + 1)));

    // R6: ready falls only after a request write
    a_r6_stall_from_request: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wr_ready) |-> $past(wr_en && wr_addr == 2'd0));

    // R7: in no-stall mode the host port never blocks
    a_r7_nostall_never_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        nostall_q |-> wr_ready);

    // R7: error bits rise only in no-stall mode
    a_r7_err_needs_nostall: assert property (@(posedge clk) disable iff (!rst_n)
        (|(err_flags & ~$past(err_flags))) |-> $past(nostall_q));

    // R8: error bits fall only after a write to the clear address
    a_r8_clear_only_by_w1c: assert property (@(posedge clk) disable iff (!rst_n)
        (|($past(err_flags) & ~err_flags)) |-> $past(wr_en && wr_ready && wr_addr == 2'd2));
endmodule

bind event_sync_counter esc_checker #(.NPORT(NPORT), .CW(CW), .NUM_COND(NUM_COND)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_ready  (wr_ready),
    .fs_evt    (fs_evt),
    .ack_evt   (ack_evt),
    .rd_idx    (rd_idx),
    .rd_count  (rd_count),
    .err_flags (err_flags),
    .nostall_q (nostall_q)
);

// File: tb/tb_event_sync_counter.sv
`timescale 1ns/1ps
module tb_event_sync_counter;
    localparam int NP = 2;
    localparam int NC = 8;
    localparam int NCOND = 4 * NP + 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             wr_en = 1'b0;
    logic [1:0]       wr_addr = '0;
    logic [31:0]      wr_data = '0;
    logic             wr_ready;
    logic [NP-1:0]    fs_evt = '0;
    logic [NP-1:0]    ack_evt = '0;
    logic [7:0]       rd_idx = '0;
    logic [31:0]      rd_count;
    logic [NCOND-1:0] err_flags;

    int checks = 0;
    int fails = 0;
    int unsigned expc [NC];
    int cyc = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    event_sync_counter #(.NPORT(NP), .NUM_CNT(NC)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_ready(wr_ready), .fs_evt(fs_evt),
        .ack_evt(ack_evt), .rd_idx(rd_idx), .rd_count(rd_count),
        .err_flags(err_flags)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic hw(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        while (!wr_ready) @(negedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic req(input int code, input int idx);
        hw(2'd0, 32'((code << 8) | idx));
    endtask

    task automatic ev(input logic [NP-1:0] f, input logic [NP-1:0] k);
        @(negedge clk);
        fs_evt = f; ack_evt = k;
        @(negedge clk);
        fs_evt = '0; ack_evt = '0;
    endtask

    task automatic rd_chk(input string req, input int i);
        rd_idx = 8'(i);
        #1;
        chk(req, rd_count, expc[i]);
    endtask

    task automatic chk_all(input string req);
        for (int i = 0; i < NC; i++) rd_chk(req, i);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog actual=%0d expected<=100000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NC; i++) expc[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R12: reset state
        chk("R12 ready", 32'(wr_ready), 32'd1);
        chk("R12 err", 32'(err_flags), 32'd0);
        chk_all("R12 counters");

        // R1 R2 R4: sweep every counter over every event condition
        for (int p = 0; p < NP; p++) begin
            for (int kind = 0; kind < 2; kind++) begin
                for (int i = 0; i < NC; i++) begin
                    req(kind ? 7 + 4 * p : 5 + 4 * p, i);
                    if (kind) ev('0, NP'(1 << p)); else ev(NP'(1 << p), '0);
                    expc[i]++;
                    rd_chk("R2 sweep", i);
                end
            end
        end

        // R4: oldest first
        req(7, 2); req(7, 5);
        ev('0, 2'b01); expc[2]++;
        chk_all("R4 order first");
        ev('0, 2'b01); expc[5]++;
        chk_all("R4 order second");

        // R5: events on empty queues
        ev(2'b11, 2'b11);
        chk_all("R5 empty events");

        // R3 R6: stall mode, third request waits
        req(5, 1); req(5, 2); req(5, 3);
        chk("R6 ready low", 32'(wr_ready), 32'd0);
        repeat (3) @(negedge clk);
        chk("R6 ready held low", 32'(wr_ready), 32'd0);
        chk("R3 no error", 32'(err_flags), 32'd0);
        ev(2'b01, '0); expc[1]++;
        chk("R6 ready back", 32'(wr_ready), 32'd1);
        chk_all("R3 head popped");
        ev(2'b01, '0); expc[2]++;
        ev(2'b01, '0); expc[3]++;
        chk_all("R6 held request kept");

        // R7: no-stall mode, drops
        hw(2'd1, 32'h100);
        req(9, 4); req(9, 5); req(9, 6);
        chk("R7 ready", 32'(wr_ready), 32'd1);
        chk("R7 err", 32'(err_flags), 32'(1 << 9));
        req(11, 0); req(11, 0); req(11, 7);
        chk("R7 err two", 32'(err_flags), 32'((1 << 9) | (1 << 11)));

        // R8: write-one-to-clear
        hw(2'd2, 32'(1 << 9));
        chk("R8 partial clear", 32'(err_flags), 32'(1 << 11));
        ev(2'b10, '0); expc[4]++;
        ev(2'b10, '0); expc[5]++;
        ev(2'b10, '0);
        chk_all("R7 dropped never counted");
        hw(2'd2, 32'(1 << 11));
        chk("R8 full clear", 32'(err_flags), 32'd0);
        ev('0, 2'b10); expc[0]++;
        ev('0, 2'b10); expc[0]++;
        chk_all("R7 kept entries");

        // R9: push and pop on full queue in one cycle
        req(5, 1); req(5, 2);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 2'd0; wr_data = 32'((5 << 8) | 3); fs_evt = 2'b01;
        @(negedge clk);
        wr_en = 1'b0; fs_evt = '0;
        expc[1]++;
        chk("R9 no error", 32'(err_flags), 32'd0);
        chk_all("R9 pop");
        ev(2'b01, '0); expc[2]++;
        ev(2'b01, '0); expc[3]++;
        chk_all("R9 push kept");

        // R11: four pops to one counter
        req(5, 6); req(7, 6); req(9, 6); req(11, 6);
        ev(2'b11, 2'b11); expc[6] += 4;
        chk_all("R11 multi pop");

        // R10: direct bump and out-of-range index
        hw(2'd3, 32'd4); expc[4]++;
        hw(2'd3, 32'd200);
        chk_all("R10 bump");

        // R1: out-of-range condition code has no effect
        req(40, 2);
        chk("R1 ready", 32'(wr_ready), 32'd1);
        chk("R1 err", 32'(err_flags), 32'd0);
        ev(2'b11, 2'b11);
        chk_all("R1 ignored code");

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule